// File: doc/BRIEF.md
# Serial NAND Page Operation Sequencer

This block is the command layer of a serial NAND flash controller. A host starts one high-level request at a time: device reset, initialisation, page read, page program or block erase. The block expands that request into the ordered list of flash commands it needs and hands each one as a descriptor to a separate serial phase engine. That engine shifts the opcode, address, dummy and data phases on the wires and moves the page data itself.

For the commands that start an array operation inside the flash, the block reads the device status register over and over until the device reports that it is idle. It stops with a timeout if a programmable number of busy readings is reached. It then decodes the status fail bits and ECC field and ends the request with a one-cycle done pulse that carries an error code and a two-bit ECC result. Operands are captured when the request is accepted. The host may change its inputs while a request is running.

Top module: `nand_seq_top`

## Requirements
- R1: After reset, busy, done and desc_valid are 0, and err_code and ecc_result are 0.
- R2: A reset request (req_code 0) issues opcode 0xFF with no address (alen 0, dir 0), then polls status, then ends with err_code 0.
- R3: An init request (req_code 1) issues two set-feature writes with opcode 0x1F, 1-byte address and dir 2 (out). The first writes 0x00 to address 0xA0. The second writes 0x11 to address 0xB0, which sets the ECC-enable bit 4 and the quad-enable bit 0. No status poll follows.
- R4: A page read (req_code 2) issues 0x13 with the 3-byte row address, then polls status, then issues the cache read with the 2-byte column address and dir 1 (in). The cache read uses opcode 0x03 with 0 dummy bytes, or 0x0B with 1 dummy byte when fast_read is set. ecc_result reports status bits [5:4].
- R5: In a page read whose final status has bits [5:4] equal to 2'b10, the cache read is skipped and the request ends with err_code 3 (uncorrectable) and ecc_result 2'b10.
- R6: A program (req_code 3) issues a cache load with the 2-byte column and dir 2, then write enable 0x06, then 0x10 with the 3-byte row, then polls status. The cache load uses opcode 0x02, or 0x84 when keep_cache is set. Status bit 3 set gives err_code 1.
- R7: An erase (req_code 4) issues write enable 0x06, then 0xD8 with the 3-byte row, then polls status. Status bit 2 set gives err_code 2. Every 0x10 or 0xD8 descriptor directly follows a 0x06 descriptor.
- R8: A status poll is opcode 0x0F with 1-byte address 0xC0 and dir 1. It is reissued while bit 0 of the returned byte is 1, and the request proceeds when bit 0 is 0.
- R9: When the number of busy readings in one poll reaches poll_limit, the request ends with err_code 4 (timeout) and no further descriptor is issued.
- R10: done is high for exactly one cycle per accepted request. err_code and ecc_result are 0 whenever done is 0. ecc_result is 0 for requests other than page read.
- R11: A descriptor stays on the outputs, unchanged, until desc_ready is high. The next descriptor is not offered until rsp_valid has returned for the previous one.
- R12: start is ignored while busy, and a request code above 4 is ignored (no descriptor, no done). row_addr, col_addr, fast_read, keep_cache and poll_limit are sampled only when a request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, taken when idle |
| req_code | input | 3 | 0 reset, 1 init, 2 read, 3 program, 4 erase |
| row_addr | input | 24 | Page (row) address |
| col_addr | input | 16 | Byte (column) address in the page cache |
| fast_read | input | 1 | Use the fast cache read with one dummy byte |
| keep_cache | input | 1 | Program load that keeps the rest of the cache |
| poll_limit | input | TMO_W | Busy readings that make a timeout |
| desc_valid | output | 1 | Descriptor offered to the phase engine |
| desc_ready | input | 1 | Phase engine takes the descriptor |
| desc_opcode | output | 8 | Command opcode |
| desc_addr | output | 24 | Address value, right-aligned |
| desc_alen | output | 2 | Address bytes (0 to 3) |
| desc_dummy | output | 2 | Dummy bytes |
| desc_dir | output | 2 | Data phase: 0 none, 1 in, 2 out |
| desc_wdata | output | 8 | Byte written by a set-feature command |
| rsp_valid | input | 1 | Phase engine finished the last descriptor |
| rsp_data | input | 8 | Byte read back (status for polls) |
| busy | output | 1 | A request is running |
| done | output | 1 | One-cycle end-of-request pulse |
| err_code | output | 3 | 0 ok, 1 program fail, 2 erase fail, 3 uncorrectable, 4 timeout |
| ecc_result | output | 2 | Status ECC field of a page read |

## Verification
The bench targets polls that see several busy readings before going idle, a timeout at an exact count of three, and status bytes that carry fail or ECC bits together with busy. A design that skips one of those busy readings, decodes the wrong bit or counts one too many would send the wrong number of 0x0F descriptors or the wrong code. The phase engine model withholds ready on alternate cycles and delays its responses, so a sequencer that drops or changes a stalled descriptor, or runs ahead of a response, shows up as a mismatched descriptor stream. Inputs are changed right after acceptance and a second start is pulsed during an erase, which catches a design that reads live inputs or accepts a nested request.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

    localparam int ADDR_W = 24;
    localparam int COL_W  = 16;
    localparam int IDX_W  = 3;

    localparam logic [7:0] OP_RESET    = 8'hFF;
    localparam logic [7:0] OP_WREN     = 8'h06;
    localparam logic [7:0] OP_SETF     = 8'h1F;
    localparam logic [7:0] OP_GETF     = 8'h0F;
    localparam logic [7:0] OP_ARR_RD   = 8'h13;
    localparam logic [7:0] OP_CRD      = 8'h03;
    localparam logic [7:0] OP_CRD_FAST = 8'h0B;
    localparam logic [7:0] OP_LOAD     = 8'h02;
    localparam logic [7:0] OP_LOAD_KEEP= 8'h84;
    localparam logic [7:0] OP_COMMIT   = 8'h10;
    localparam logic [7:0] OP_ERASE    = 8'hD8;
    localparam logic [7:0] REG_LOCK    = 8'hA0;
    localparam logic [7:0] REG_CONF    = 8'hB0;
    localparam logic [7:0] REG_STAT    = 8'hC0;

    typedef enum logic [2:0] {
        REQ_RESET = 3'd0, REQ_INIT = 3'd1, REQ_READ = 3'd2,
        REQ_PROG  = 3'd3, REQ_ERASE = 3'd4
    } req_e;

    typedef enum logic [2:0] {
        ERR_NONE = 3'd0, ERR_PROG = 3'd1, ERR_ERASE = 3'd2,
        ERR_ECC  = 3'd3, ERR_TIMEOUT = 3'd4
    } err_e;

    typedef enum logic [1:0] {DIR_NONE = 2'd0, DIR_IN = 2'd1, DIR_OUT = 2'd2} dir_e;
    typedef enum logic [1:0] {K_SEND, K_POLL, K_END} kind_e;
    typedef enum logic [1:0] {A_NONE, A_ROW, A_COL, A_REG} asel_e;

    typedef struct packed {
        kind_e      kind;
        logic [7:0] op;
        asel_e      asel;
        logic [7:0] regaddr;
        logic [1:0] dummy;
        dir_e       dir;
        logic [7:0] wdata;
    } step_t;

    typedef struct packed {
        logic [7:0]        op;
        logic [ADDR_W-1:0] addr;
        logic [1:0]        alen;
        logic [1:0]        dummy;
        dir_e              dir;
        logic [7:0]        wdata;
    } desc_t;

    function automatic logic req_ok(logic [2:0] code);
        return code <= 3'd4;
    endfunction

    function automatic step_t snd(logic [7:0] op, asel_e a, logic [7:0] ra,
                                  logic [1:0] dm, dir_e d, logic [7:0] wd);
        step_t s;
        s = '{kind: K_SEND, op: op, asel: a, regaddr: ra, dummy: dm, dir: d, wdata: wd};
        return s;
    endfunction

    function automatic step_t poll_step();
        step_t s;
        s = '{kind: K_POLL, op: OP_GETF, asel: A_REG, regaddr: REG_STAT,
              dummy: 2'd0, dir: DIR_IN, wdata: 8'h00};
        return s;
    endfunction

    // Command program of each request, one step per index.
    function automatic step_t step_of(req_e r, logic [IDX_W-1:0] idx,
                                      logic fast, logic keep, logic [7:0] cfg);
        step_t s;
        s = '{kind: K_END, op: 8'h00, asel: A_NONE, regaddr: 8'h00,
              dummy: 2'd0, dir: DIR_NONE, wdata: 8'h00};
        case (r)
            REQ_RESET: case (idx)
                3'd0: s = snd(OP_RESET, A_NONE, 8'h00, 2'd0, DIR_NONE, 8'h00);
                3'd1: s = poll_step();
                default: ;
            endcase
            REQ_INIT: case (idx)
                3'd0: s = snd(OP_SETF, A_REG, REG_LOCK, 2'd0, DIR_OUT, 8'h00);
                3'd1: s = snd(OP_SETF, A_REG, REG_CONF, 2'd0, DIR_OUT, cfg);
                default: ;
            endcase
            REQ_READ: case (idx)
                3'd0: s = snd(OP_ARR_RD, A_ROW, 8'h00, 2'd0, DIR_NONE, 8'h00);
                3'd1: s = poll_step();
                3'd2: s = snd(fast ? OP_CRD_FAST : OP_CRD, A_COL, 8'h00,
                              fast ? 2'd1 : 2'd0, DIR_IN, 8'h00);
                default: ;
            endcase
            REQ_PROG: case (idx)
                3'd0: s = snd(keep ? OP_LOAD_KEEP : OP_LOAD, A_COL, 8'h00, 2'd0, DIR_OUT, 8'h00);
                3'd1: s = snd(OP_WREN, A_NONE, 8'h00, 2'd0, DIR_NONE, 8'h00);
                3'd2: s = snd(OP_COMMIT, A_ROW, 8'h00, 2'd0, DIR_NONE, 8'h00);
                3'd3: s = poll_step();
                default: ;
            endcase
            REQ_ERASE: case (idx)
                3'd0: s = snd(OP_WREN, A_NONE, 8'h00, 2'd0, DIR_NONE, 8'h00);
                3'd1: s = snd(OP_ERASE, A_ROW, 8'h00, 2'd0, DIR_NONE, 8'h00);
                3'd2: s = poll_step();
                default: ;
            endcase
            default: ;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/nand_step_table.sv
module nand_step_table
    import nand_seq_pkg::*;
#(
    parameter logic [7:0] CFG_VAL = 8'h11
) (
    input  req_e                   req,
    input  logic [IDX_W-1:0]       idx,
    input  logic                   fast,
    input  logic                   keep,
    input  logic [ADDR_W-1:0]      row,
    input  logic [COL_W-1:0]       col,
    output kind_e                  kind,
    output desc_t                  desc
);
    step_t st;

    always_comb begin
        st         = step_of(req, idx, fast, keep, CFG_VAL);
        kind       = st.kind;
        desc.op    = st.op;
        desc.dummy = st.dummy;
        desc.dir   = st.dir;
        desc.wdata = st.wdata;
        case (st.asel)
            A_ROW:   begin desc.addr = row;                            desc.alen = 2'd3; end
            A_COL:   begin desc.addr = {{(ADDR_W-COL_W){1'b0}}, col};  desc.alen = 2'd2; end
            A_REG:   begin desc.addr = {{(ADDR_W-8){1'b0}}, st.regaddr}; desc.alen = 2'd1; end
            default: begin desc.addr = '0;                             desc.alen = 2'd0; end
        endcase
    end
endmodule

// File: rtl/nand_poll_timer.sv
module nand_poll_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    input  logic [W-1:0] limit,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) cnt <= '0;
        else if (inc)   cnt <= cnt + 1'b1;
    end

    // The busy reading now being handled is number cnt+1.
    assign expired = ({1'b0, cnt} + (W+1)'(1)) >= {1'b0, limit};
endmodule

// File: rtl/nand_status_decode.sv
module nand_status_decode
    import nand_seq_pkg::*;
(
    input  req_e       req,
    input  logic [7:0] status,
    output logic       dev_busy,
    output err_e       err,
    output logic [1:0] ecc
);
    always_comb begin
        dev_busy = status[0];
        ecc      = (req == REQ_READ) ? status[5:4] : 2'b00;
        err      = ERR_NONE;
        if (req == REQ_PROG && status[3])                 err = ERR_PROG;
        else if (req == REQ_ERASE && status[2])           err = ERR_ERASE;
        else if (req == REQ_READ && status[5:4] == 2'b10) err = ERR_ECC;
    end
endmodule

// File: rtl/nand_seq_top.sv
module nand_seq_top
    import nand_seq_pkg::*;
#(
    parameter int TMO_W   = 16,
    parameter bit QUAD_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [2:0]        req_code,
    input  logic [23:0]       row_addr,
    input  logic [15:0]       col_addr,
    input  logic              fast_read,
    input  logic              keep_cache,
    input  logic [TMO_W-1:0]  poll_limit,
    output logic              desc_valid,
    input  logic              desc_ready,
    output logic [7:0]        desc_opcode,
    output logic [23:0]       desc_addr,
    output logic [1:0]        desc_alen,
    output logic [1:0]        desc_dummy,
    output logic [1:0]        desc_dir,
    output logic [7:0]        desc_wdata,
    input  logic              rsp_valid,
    input  logic [7:0]        rsp_data,
    output logic              busy,
    output logic              done,
    output logic [2:0]        err_code,
    output logic [1:0]        ecc_result
);
    localparam logic [7:0] CFG_VAL = 8'h10 | {7'd0, QUAD_EN};

    typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_DONE} state_e;

    state_e              state;
    req_e                req_q;
    logic [ADDR_W-1:0]   row_q;
    logic [COL_W-1:0]    col_q;
    logic                fast_q, keep_q;
    logic [TMO_W-1:0]    lim_q;
    logic [IDX_W-1:0]    idx;
    err_e                err_q;
    logic [1:0]          ecc_q;

    kind_e               kind;
    desc_t               cur;
    logic                dev_busy, expired;
    err_e                dec_err;
    logic [1:0]          dec_ecc;
    logic                t_clr, t_inc;

    nand_step_table #(.CFG_VAL(CFG_VAL)) u_table (
        .req(req_q), .idx(idx), .fast(fast_q), .keep(keep_q),
        .row(row_q), .col(col_q), .kind(kind), .desc(cur)
    );

    nand_status_decode u_dec (
        .req(req_q), .status(rsp_data), .dev_busy(dev_busy),
        .err(dec_err), .ecc(dec_ecc)
    );

    nand_poll_timer #(.W(TMO_W)) u_timer (
        .clk(clk), .rst(rst), .clr(t_clr), .inc(t_inc),
        .limit(lim_q), .expired(expired)
    );

    wire poll_rsp = (state == S_WAIT) && rsp_valid && (kind == K_POLL);
    assign t_inc = poll_rsp && dev_busy && !expired;
    assign t_clr = (state == S_IDLE) || (poll_rsp && !dev_busy);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_IDLE;
            req_q  <= REQ_RESET;
            row_q  <= '0;
            col_q  <= '0;
            fast_q <= 1'b0;
            keep_q <= 1'b0;
            lim_q  <= '0;
            idx    <= '0;
            err_q  <= ERR_NONE;
            ecc_q  <= 2'b00;
        end else begin
            case (state)
                S_IDLE: if (start && req_ok(req_code)) begin
                    req_q  <= req_e'(req_code);
                    row_q  <= row_addr;
                    col_q  <= col_addr;
                    fast_q <= fast_read;
                    keep_q <= keep_cache;
                    lim_q  <= poll_limit;
                    idx    <= '0;
                    err_q  <= ERR_NONE;
                    ecc_q  <= 2'b00;
                    state  <= S_ISSUE;
                end
                S_ISSUE: begin
                    if (kind == K_END)   state <= S_DONE;
                    else if (desc_ready) state <= S_WAIT;
                end
                S_WAIT: if (rsp_valid) begin
                    if (kind == K_POLL) begin
                        if (dev_busy) begin
                            if (expired) begin
                                err_q <= ERR_TIMEOUT;
                                state <= S_DONE;
                            end else begin
                                state <= S_ISSUE;
                            end
                        end else begin
                            ecc_q <= dec_ecc;
                            if (dec_err != ERR_NONE) begin
                                err_q <= dec_err;
                                state <= S_DONE;
                            end else begin
                                idx   <= idx + 1'b1;
                                state <= S_ISSUE;
                            end
                        end
                    end else begin
                        idx   <= idx + 1'b1;
                        state <= S_ISSUE;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign desc_valid  = (state == S_ISSUE) && (kind != K_END);
    assign desc_opcode = cur.op;
    assign desc_addr   = cur.addr;
    assign desc_alen   = cur.alen;
    assign desc_dummy  = cur.dummy;
    assign desc_dir    = cur.dir;
    assign desc_wdata  = cur.wdata;
    assign busy        = (state != S_IDLE);
    assign done        = (state == S_DONE);
    assign err_code    = done ? err_q : ERR_NONE;
    assign ecc_result  = done ? ecc_q : 2'b00;
endmodule

// File: rtl/nand_seq_chk.sv
module nand_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        done,
    input logic [2:0]  err_code,
    input logic [1:0]  ecc_result,
    input logic        desc_valid,
    input logic        desc_ready,
    input logic [7:0]  desc_opcode,
    input logic [23:0] desc_addr,
    input logic [1:0]  desc_alen,
    input logic [1:0]  desc_dir
);
    logic [7:0] last_op;

    always_ff @(posedge clk) begin
        if (rst) last_op <= 8'h00;
        else if (desc_valid && desc_ready) last_op <= desc_opcode;
    end

    p_hold_desc_r11: assert property (@(posedge clk) disable iff (rst)
        desc_valid && !desc_ready |=> desc_valid && $stable(desc_opcode)
            && $stable(desc_addr) && $stable(desc_dir));

    // R6 and R7: commit and erase come straight after write enable
    p_wren_first_r7: assert property (@(posedge clk) disable iff (rst)
        desc_valid && desc_ready && (desc_opcode == 8'h10 || desc_opcode == 8'hD8)
            |-> last_op == 8'h06);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_quiet_out_r10: assert property (@(posedge clk) disable iff (rst)
        !done |-> err_code == 3'd0 && ecc_result == 2'b00);

    p_idle_silent_r12: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !desc_valid && !done);

    p_poll_form_r8: assert property (@(posedge clk) disable iff (rst)
        desc_valid && desc_opcode == 8'h0F |->
            desc_addr == 24'h0000C0 && desc_alen == 2'd1 && desc_dir == 2'd1);
endmodule

bind nand_seq_top nand_seq_chk u_chk (.*);

// File: tb/test_nand_seq_top.sv
module test_nand_seq_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  req_code = 3'd0;
    logic [23:0] row_addr = '0;
    logic [15:0] col_addr = '0;
    logic        fast_read = 1'b0, keep_cache = 1'b0;
    logic [15:0] poll_limit = 16'd100;
    logic        desc_valid, desc_ready;
    logic [7:0]  desc_opcode, desc_wdata;
    logic [23:0] desc_addr;
    logic [1:0]  desc_alen, desc_dummy, desc_dir;
    logic        rsp_valid;
    logic [7:0]  rsp_data;
    logic        busy, done;
    logic [2:0]  err_code;
    logic [1:0]  ecc_result;

    always #10 clk = ~clk;

    nand_seq_top i_nand_seq_top (.*);

    typedef struct {int op; int addr; int alen; int dummy; int dir; int wd;} ed_t;
    ed_t  exq[$];
    int   stat_q[$];
    int   vectors = 0, miscompares = 0;
    int   cyc = 0, pend = 0, pend_data = 0, hs_cnt = 0, done_cnt = 0;
    int   lat = 2;
    bit   rdy_alt = 1'b0;
    int   exp_err = 0, exp_ecc = 0;
    string cur_tag = "R1";

    initial begin
        desc_ready = 1'b0;
        rsp_valid  = 1'b0;
        rsp_data   = 8'h00;
    end

    task automatic chk(bit ok, string tag, string what, int act, int expv);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    task automatic ex(int op, int addr, int alen, int dummy, int dir, int wd);
        ed_t e;
        e = '{op: op, addr: addr, alen: alen, dummy: dummy, dir: dir, wd: wd};
        exq.push_back(e);
    endtask

    task automatic ex_poll(int n);
        for (int i = 0; i < n; i++) ex(8'h0F, 8'hC0, 1, 0, 1, 0);
    endtask

    // Behavioural phase engine and per-clock comparison
    always @(negedge clk) begin
        cyc++;
        if (rst) begin
            desc_ready = 1'b0;
            rsp_valid  = 1'b0;
            pend = 0;
        end else begin
            rsp_valid = 1'b0;
            if (pend > 0) begin
                pend--;
                if (pend == 0) begin
                    rsp_valid = 1'b1;
                    rsp_data  = 8'(pend_data);
                end
            end
            desc_ready = rdy_alt ? (cyc % 2 == 1) : 1'b1;
            if (desc_valid)
                chk(pend == 0 && !rsp_valid, "R11", "descriptor before response", pend, 0);
            if (desc_valid && desc_ready) begin
                hs_cnt++;
                if (exq.size() == 0) begin
                    chk(1'b0, cur_tag, "unexpected opcode", int'(desc_opcode), -1);
                end else begin
                    ed_t e;
                    e = exq.pop_front();
                    chk(desc_opcode == 8'(e.op), cur_tag, "opcode", int'(desc_opcode), e.op);
                    chk(desc_addr == 24'(e.addr) && desc_alen == 2'(e.alen), cur_tag,
                        "addr/alen", int'({desc_alen, desc_addr}), (e.alen << 24) | e.addr);
                    chk(desc_dummy == 2'(e.dummy) && desc_dir == 2'(e.dir), cur_tag,
                        "dummy/dir", int'({desc_dummy, desc_dir}), (e.dummy << 2) | e.dir);
                    chk(desc_wdata == 8'(e.wd), cur_tag, "wdata", int'(desc_wdata), e.wd);
                end
                pend = lat;
                pend_data = (desc_opcode == 8'h0F && stat_q.size() > 0) ? stat_q.pop_front() : 0;
            end
            if (done) begin
                done_cnt++;
                chk(exq.size() == 0, cur_tag, "descriptors left at done", exq.size(), 0);
                chk(err_code == 3'(exp_err), cur_tag, "err_code", int'(err_code), exp_err);
                chk(ecc_result == 2'(exp_ecc), cur_tag, "ecc_result", int'(ecc_result), exp_ecc);
            end
        end
    end

    task automatic run(int rq, int row, int col, bit fast, bit keep, int lim,
                       int eerr, int eecc, string tag, bit poke);
        int d0, w;
        d0 = done_cnt;
        w = 0;
        exp_err = eerr;
        exp_ecc = eecc;
        cur_tag = tag;
        @(negedge clk); #1;
        req_code = 3'(rq); row_addr = 24'(row); col_addr = 16'(col);
        fast_read = fast; keep_cache = keep; poll_limit = 16'(lim); start = 1'b1;
        @(negedge clk); #1;
        start = 1'b0;
        // R12: later input changes must not reach the descriptors
        row_addr = 24'h5A5A5A; col_addr = 16'hA5A5;
        fast_read = ~fast; keep_cache = ~keep; poll_limit = 16'd1;
        if (poke) begin
            repeat (3) @(negedge clk);
            #1 req_code = 3'd2; start = 1'b1;
            @(negedge clk); #1 start = 1'b0;
        end
        while (done_cnt == d0 && w < 5000) begin
            @(negedge clk); w++;
        end
        #1;
        chk(done_cnt != d0, tag, "request finished", done_cnt - d0, 1);
        repeat (4) @(negedge clk);
        #1;
        chk(done_cnt == d0 + 1 && !busy, "R10", "single done then idle", done_cnt - d0, 1);
        stat_q.delete();
        exq.delete();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst = 1'b0;
        chk(!busy && !done && !desc_valid, "R1", "idle after reset",
            int'({busy, done, desc_valid}), 0);
        chk(err_code == 3'd0 && ecc_result == 2'd0, "R1", "codes after reset",
            int'({err_code, ecc_result}), 0);

        // R2: reset with one busy reading
        ex(8'hFF, 0, 0, 0, 0, 0); ex_poll(2);
        stat_q = '{8'h01, 8'h00};
        run(0, 0, 0, 0, 0, 100, 0, 0, "R2", 0);

        // R3: init writes lock then config
        ex(8'h1F, 8'hA0, 1, 0, 2, 8'h00); ex(8'h1F, 8'hB0, 1, 0, 2, 8'h11);
        run(1, 0, 0, 0, 0, 100, 0, 0, "R3", 0);

        // R4: normal read, corrected ECC, ready stalls
        rdy_alt = 1'b1; lat = 3;
        ex(8'h13, 24'h012345, 3, 0, 0, 0); ex_poll(1); ex(8'h03, 16'h0804, 2, 0, 1, 0);
        stat_q = '{8'h10};
        run(2, 24'h012345, 16'h0804, 0, 0, 100, 0, 1, "R4", 0);

        // R4: fast read after two busy readings
        ex(8'h13, 24'hFEDCBA, 3, 0, 0, 0); ex_poll(3); ex(8'h0B, 16'h0000, 2, 1, 1, 0);
        stat_q = '{8'h01, 8'h11, 8'h00};
        run(2, 24'hFEDCBA, 16'h0000, 1, 0, 100, 0, 0, "R4", 0);
        rdy_alt = 1'b0; lat = 2;

        // R5: uncorrectable skips the cache read
        ex(8'h13, 24'h000777, 3, 0, 0, 0); ex_poll(1);
        stat_q = '{8'h20};
        run(2, 24'h000777, 16'h0010, 0, 0, 100, 3, 2, "R5", 0);

        // R6: program ok, normal load
        ex(8'h02, 16'h0100, 2, 0, 2, 0); ex(8'h06, 0, 0, 0, 0, 0);
        ex(8'h10, 24'h00ABCD, 3, 0, 0, 0); ex_poll(2);
        stat_q = '{8'h01, 8'h00};
        run(3, 24'h00ABCD, 16'h0100, 0, 0, 100, 0, 0, "R6", 0);

        // R6: program fail with cache-keeping load
        ex(8'h84, 16'h0002, 2, 0, 2, 0); ex(8'h06, 0, 0, 0, 0, 0);
        ex(8'h10, 24'h100000, 3, 0, 0, 0); ex_poll(1);
        stat_q = '{8'h08};
        run(3, 24'h100000, 16'h0002, 0, 1, 100, 1, 0, "R6", 0);

        // R7 and R8: erase with three readings and a nested start (R12)
        lat = 4;
        ex(8'h06, 0, 0, 0, 0, 0); ex(8'hD8, 24'h000040, 3, 0, 0, 0); ex_poll(3);
        stat_q = '{8'h01, 8'h05, 8'h00};
        run(4, 24'h000040, 0, 0, 0, 100, 0, 0, "R8", 1);
        lat = 2;

        // R7: erase fail
        ex(8'h06, 0, 0, 0, 0, 0); ex(8'hD8, 24'h0003C0, 3, 0, 0, 0); ex_poll(1);
        stat_q = '{8'h04};
        run(4, 24'h0003C0, 0, 0, 0, 100, 2, 0, "R7", 0);

        // R9: timeout at exactly three busy readings
        ex(8'h06, 0, 0, 0, 0, 0); ex(8'hD8, 24'h000080, 3, 0, 0, 0); ex_poll(3);
        stat_q = '{8'h01, 8'h01, 8'h01, 8'h01, 8'h01};
        run(4, 24'h000080, 0, 0, 0, 3, 4, 0, "R9", 0);

        // R12: unknown request code is ignored
        begin
            int h0, d0;
            h0 = hs_cnt; d0 = done_cnt; cur_tag = "R12";
            @(negedge clk); #1 req_code = 3'd7; start = 1'b1;
            @(negedge clk); #1 start = 1'b0;
            repeat (10) @(negedge clk);
            #1;
            chk(hs_cnt == h0 && done_cnt == d0 && !busy, "R12", "bad code ignored",
                hs_cnt - h0 + done_cnt - d0, 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule